// File: doc/BRIEF.md
# Bit-Serial Lookup-Table FIR Filter

This block is an eight-tap low-pass FIR filter that computes its output without a single multiplier. Every accepted signed sample is pushed into a delay line of eight taps. The filter then visits the bit positions of the stored samples one per cycle, least significant first. The eight bits found at one position form a bit plane. The plane is cut into two four-bit halves, and each half selects a precomputed sum of coefficients from its own sixteen-entry table. The two table outputs are added, and the result is scaled by the weight of the bit position and accumulated.

The coefficients are a fixed, symmetric (linear-phase) parameter vector. Both tables are filled with constants at elaboration. Three register stages separate the lookup, the half-sum adder and the accumulator. Samples are presented with a one-cycle valid strobe. A strobe that arrives while a previous sample is still being processed is dropped, so the source is expected to pace itself to one sample per eleven cycles. Each accepted sample produces exactly one full-precision result with its own one-cycle strobe.

Top module: `dafir_filter`

## Requirements
- R1: A synchronous active-high reset drives out_valid and out_data to 0 and empties the delay line, so the first result after reset depends only on the first coefficient and the first sample.
- R2: For each accepted sample x[n], out_data equals the sum over k = 0..7 of c[k]·x[n−k], where x[n−k] is the k-th previously accepted sample (0 if none since reset) and the default coefficients are c = {−20, 35, 290, 720, 720, 290, 35, −20}.
- R3: A sample is accepted at a rising edge where in_valid is 1 and the filter is idle. out_valid is 1 for exactly one cycle, beginning 10 rising edges after the accepting edge.
- R4: The filter is busy from the accepting edge up to and including the edge at which out_valid rises. in_valid during that time is ignored: the sample does not enter the delay line and no extra result is produced. A sample can be accepted in the cycle in which out_valid is 1.
- R5: in_data is 8-bit two's complement. Bit 7 carries weight −128, and −128 is handled exactly.
- R6: out_data is a 23-bit two's complement value. It holds the exact result for every input pattern, including all taps at −128 and all taps at +127, with no wrap.
- R7: out_data keeps its last value between strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample strobe |
| in_data | input | 8 | Signed input sample |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 23 | Signed filter result |

## Verification
The assertions assume that in_valid and in_data are stable around the rising edge. The accumulator's no-wrap check relies on the coefficient set being the default one or one of similar magnitude, so that the 23-bit result width covers the worst case. The stimulus drives inputs only on falling edges and uses only the default coefficients. It also holds in_valid high through whole busy windows, which exercises the drop rule without ever violating the timing that the assertions take for granted.

// File: rtl/dafir_pkg.sv
package dafir_pkg;

    localparam int TAPS = 8;
    localparam int GRP  = 4;
    localparam int NGRP = TAPS / GRP;
    localparam int NENT = 1 << GRP;
    localparam int XW   = 8;
    localparam int CW   = 12;
    localparam int PSW  = CW + $clog2(GRP);
    localparam int SW   = PSW + $clog2(NGRP);
    localparam int AW   = XW + CW + $clog2(TAPS);
    localparam int BIW  = $clog2(XW);

    typedef logic signed [CW-1:0]  coef_t;
    typedef coef_t [TAPS-1:0]      coef_vec_t;
    typedef logic signed [XW-1:0]  samp_t;
    typedef logic signed [PSW-1:0] psum_t;
    typedef logic signed [SW-1:0]  gsum_t;
    typedef logic signed [AW-1:0]  acc_t;
    typedef logic [BIW-1:0]        bidx_t;

    localparam bidx_t TOP_IDX = bidx_t'(XW - 1);

    // per-plane control carried alongside the datapath
    typedef struct packed {
        logic  vld;
        logic  last;
        logic  neg;
        bidx_t idx;
    } tag_t;

    localparam coef_vec_t DEFAULT_COEFS = {
        -12'sd20, 12'sd35, 12'sd290, 12'sd720,
        12'sd720, 12'sd290, 12'sd35, -12'sd20
    };

    // sum of the coefficients of group g selected by address bits
    function automatic psum_t ps_entry(coef_vec_t c, int g, logic [GRP-1:0] a);
        psum_t s;
        s = '0;
        for (int k = 0; k < GRP; k++) begin
            if (a[k]) s = psum_t'(s + psum_t'(c[g*GRP + k]));
        end
        return s;
    endfunction

endpackage

// File: rtl/dafir_tapline.sv
module dafir_tapline
    import dafir_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  samp_t           din,
    input  bidx_t           idx,
    output logic [TAPS-1:0] plane
);

    samp_t [TAPS-1:0] taps;

    always_ff @(posedge clk) begin
        if (rst) begin
            taps <= '0;
        end else if (load) begin
            taps[0] <= din;
            for (int k = 1; k < TAPS; k++) taps[k] <= taps[k-1];
        end
    end

    always_comb begin
        for (int k = 0; k < TAPS; k++) plane[k] = taps[k][idx];
    end

    // R2: newest tap receives the accepted sample
    assert_shift_in_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> taps[0] == $past(din));

    // R4: without a load the delay line never moves
    assert_hold_idle_R4: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(taps));

endmodule

// File: rtl/dafir_ptable.sv
module dafir_ptable
    import dafir_pkg::*;
#(
    parameter coef_vec_t COEFS = DEFAULT_COEFS,
    parameter int        GIDX  = 0
)(
    input  logic           clk,
    input  logic           rst,
    input  logic [GRP-1:0] addr,
    output psum_t          ps
);

    psum_t rom [NENT];

    for (genvar a = 0; a < NENT; a++) begin : g_ent
        localparam psum_t ENTRY = ps_entry(COEFS, GIDX, GRP'(a));
        assign rom[a] = ENTRY;
    end

    always_ff @(posedge clk) begin
        if (rst) ps <= '0;
        else     ps <= rom[addr];
    end

endmodule

// File: rtl/dafir_accum.sv
module dafir_accum
    import dafir_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  psum_t [NGRP-1:0]  ps_vec,
    input  tag_t              tag_in,
    output logic              last_step,
    output logic              y_vld,
    output acc_t              y_data
);

    gsum_t sum_c, sum_q;
    tag_t  tag2;
    acc_t  acc_q, acc_base, acc_term, acc_next;

    always_comb begin
        sum_c = '0;
        for (int g = 0; g < NGRP; g++) sum_c = gsum_t'(sum_c + gsum_t'($signed(ps_vec[g])));
    end

    // stage 2: add the two half-plane sums
    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            tag2  <= '0;
        end else begin
            sum_q <= sum_c;
            tag2  <= tag_in;
        end
    end

    always_comb begin
        acc_term = acc_t'(sum_q) <<< tag2.idx;
        if (tag2.neg) acc_term = -acc_term;
        acc_base = (tag2.idx == '0) ? '0 : acc_q;
        acc_next = acc_base + acc_term;
    end

    assign last_step = tag2.vld && tag2.last;

    // stage 3: weighted accumulate and result register
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            y_vld  <= 1'b0;
            y_data <= '0;
        end else begin
            y_vld <= last_step;
            if (tag2.vld) acc_q <= acc_next;
            if (last_step) y_data <= acc_next;
        end
    end

    // R2: bit planes reach the accumulator in consecutive order
    assert_plane_order_R2: assert property (@(posedge clk) disable iff (rst)
        (tag2.vld && tag2.idx != '0) |-> ($past(tag2.vld) && $past(tag2.idx) == tag2.idx - 1'b1));

    // R6: the accumulate step never wraps
    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        (tag2.vld && acc_base[AW-1] == acc_term[AW-1]) |-> acc_next[AW-1] == acc_base[AW-1]);

    // R3: result strobe lasts one cycle
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        y_vld |=> !y_vld);

endmodule

// File: rtl/dafir_filter.sv
module dafir_filter
    import dafir_pkg::*;
#(
    parameter coef_vec_t COEFS = DEFAULT_COEFS
)(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [XW-1:0] in_data,
    output logic          out_valid,
    output logic [AW-1:0] out_data
);

    logic             busy, issuing, accept, last_step;
    bidx_t            bidx_q;
    logic [TAPS-1:0]  plane;
    psum_t [NGRP-1:0] ps_vec;
    tag_t             issue_tag, tag1;
    acc_t             y_data;

    assign accept = in_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy    <= 1'b0;
            issuing <= 1'b0;
            bidx_q  <= '0;
        end else if (accept) begin
            busy    <= 1'b1;
            issuing <= 1'b1;
            bidx_q  <= '0;
        end else begin
            if (issuing) begin
                if (bidx_q == TOP_IDX) issuing <= 1'b0;
                else                   bidx_q  <= bidx_q + 1'b1;
            end
            if (last_step) busy <= 1'b0;
        end
    end

    dafir_tapline u_taps (
        .clk   (clk),
        .rst   (rst),
        .load  (accept),
        .din   (samp_t'(in_data)),
        .idx   (bidx_q),
        .plane (plane)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_tbl
        dafir_ptable #(.COEFS(COEFS), .GIDX(g)) u_tbl (
            .clk  (clk),
            .rst  (rst),
            .addr (plane[g*GRP +: GRP]),
            .ps   (ps_vec[g])
        );
    end

    always_comb begin
        issue_tag.vld  = issuing;
        issue_tag.last = (bidx_q == TOP_IDX);
        issue_tag.neg  = (bidx_q == TOP_IDX);
        issue_tag.idx  = bidx_q;
    end

    // stage 1 control, aligned with the table registers
    always_ff @(posedge clk) begin
        if (rst) tag1 <= '0;
        else     tag1 <= issue_tag;
    end

    dafir_accum u_acc (
        .clk       (clk),
        .rst       (rst),
        .ps_vec    (ps_vec),
        .tag_in    (tag1),
        .last_step (last_step),
        .y_vld     (out_valid),
        .y_data    (y_data)
    );

    assign out_data = y_data;

    // R3: a result is presented only once the filter is idle again
    assert_out_idle_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !busy);

    // R4: bit planes are issued only inside a busy window
    assert_issue_busy_R4: assert property (@(posedge clk) disable iff (rst)
        issuing |-> busy);

endmodule

// File: tb/sim_dafir_filter.sv
`timescale 1ns/1ps
module sim_dafir_filter;

    localparam int LAT = 10;
    localparam int NT  = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        out_valid;
    logic [22:0] out_data;

    int checks = 0;
    int errors = 0;
    string cur_req = "R1";

    int coef [NT] = '{-20, 35, 290, 720, 720, 290, 35, -20};
    int hist [NT];
    int cnt = 0;
    int pending = 0;
    bit mvalid = 0;
    int mdata = 0;

    always #2 clk = ~clk;

    dafir_filter u0 (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    // behavioural reference, one step per rising edge
    always @(posedge clk) begin
        if (rst) begin
            cnt = 0; mvalid = 0; mdata = 0; pending = 0;
            for (int k = 0; k < NT; k++) hist[k] = 0;
        end else begin
            mvalid = 0;
            if (cnt == 1) begin
                mvalid = 1;
                mdata  = pending;
            end
            if (cnt > 0) begin
                cnt--;
            end else if (in_valid) begin
                for (int k = NT - 1; k > 0; k--) hist[k] = hist[k-1];
                hist[0] = int'($signed(in_data));
                pending = 0;
                for (int k = 0; k < NT; k++) pending += coef[k] * hist[k];
                cnt = LAT;
            end
        end
    end

    // compare on every falling edge
    always @(negedge clk) begin
        if (!rst) begin
            checks++;
            if (out_valid !== mvalid) begin
                errors++;
                $display("FAIL R3 out_valid actual %0b expected %0b at %0t", out_valid, mvalid, $time);
            end
            checks++;
            if (out_data !== 23'(mdata)) begin
                errors++;
                $display("FAIL %s out_data actual %0d expected %0d at %0t",
                         mvalid ? cur_req : "R7", $signed(out_data), mdata, $time);
            end
        end
    end

    task automatic send(input int v);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'(v);
        @(negedge clk);
        in_valid = 1'b0;
        repeat (LAT) @(negedge clk);
    endtask

    task automatic check_reset_state();
        checks++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            errors++;
            $display("FAIL R1 reset outputs actual %0b/%0d expected 0/0", out_valid, out_data);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check_reset_state();
        rst = 1'b0;

        // R1: first result only sees c[0]
        cur_req = "R1";
        send(5);

        // R2: impulse response and ordinary values
        cur_req = "R2";
        send(1);
        for (int i = 0; i < 8; i++) send(0);
        for (int i = 0; i < 20; i++) send(int'($urandom_range(0, 255)) - 128);

        // R5: negative samples including the most negative
        cur_req = "R5";
        send(-128); send(-1); send(-77); send(64); send(-128); send(-2);

        // R6: extreme plateaus and alternation
        cur_req = "R6";
        for (int i = 0; i < 8; i++) send(-128);
        for (int i = 0; i < 8; i++) send(127);
        for (int i = 0; i < 8; i++) send((i % 2 == 0) ? 127 : -128);

        // R4: strobe held high, new data every cycle
        cur_req = "R4";
        @(negedge clk);
        in_valid = 1'b1;
        for (int i = 0; i < 300; i++) begin
            in_data = 8'($urandom_range(0, 255));
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (LAT + 2) @(negedge clk);

        // R1: reset in the middle of a busy window
        cur_req = "R1";
        @(negedge clk);
        in_valid = 1'b1; in_data = 8'd100;
        @(negedge clk);
        in_valid = 1'b0;
        repeat (4) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check_reset_state();
        rst = 1'b0;
        send(-9);
        send(3);

        repeat (4) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule